// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a synchronous requester and an asynchronous one-bit-wide dynamic memory with a million cells. The requester issues one read or write at a time, using a 20-bit linear address. The controller splits that address into a row half and a column half and time-multiplexes them onto one set of address pins. It sequences the row strobe, the column strobe and the write-enable line, and it returns read data with a one-cycle valid pulse.

After a row is activated it stays open. A later request to the same row is served as a page cycle: only the column strobe toggles, and the row strobe stays low. The column address goes onto the pins while the column strobe is still high. This suits a device whose column latches pass data through while that strobe is high, so the access begins before the strobe falls.

A request to a different row first closes the open row and waits out the precharge time, then opens the new row. The controller also closes a row on its own before the row strobe has been low for longer than the allowed maximum. Every timing interval is a whole number of clock cycles, and each is set by a parameter.

Top module: `pdram_ctrl`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `req_ready` is high, `rd_valid` is low, and no row counts as open.
- R2: With the default split, the row half is address bits [19:10] and the column half is bits [9:0]. The row half is on `dram_addr` and stable in the cycle where `dram_ras_n` falls. The column half is on `dram_addr` and stable in the cycle where `dram_cas_n` falls.
- R3: After `dram_ras_n` falls, the row stays on the pins for T_RAH cycles, and then the column replaces it. The first `dram_cas_n` fall in a row activation comes exactly T_RCD cycles after the `dram_ras_n` fall.
- R4: When a request addresses the open row, it runs with no new row activation. `dram_ras_n` stays low, and the column goes on the pins one cycle before `dram_cas_n` falls.
- R5: When a request addresses a different row, `dram_ras_n` rises. The row strobe stays high for at least T_RP cycles before it falls again for the new row.
- R6: On a write, `dram_we_n` is low and `dram_d` carries the write bit, both stable in the cycle where `dram_cas_n` falls. On a read, `dram_we_n` stays high.
- R7: A read produces exactly one `rd_valid` pulse of one cycle. `rd_data` holds the bit stored at the address, sampled T_ACC cycles after `dram_cas_n` falls.
- R8: `dram_ras_n` never stays low for more than T_RAS_MAX cycles. An open row is closed even while requests keep hitting it.
- R9: `req_ready` goes low in the cycle after a request is accepted. It stays low until the access, including column precharge, has finished.
- R10: `dram_cas_n` is low for exactly T_CAS cycles and only while `dram_ras_n` is low. Between page cycles it stays high for at least T_CP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W (20) | Linear cell address |
| req_wdata | input | 1 | Bit to write |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read result |
| rd_data | output | 1 | Read result |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) (10) | Multiplexed row/column address |
| dram_d | output | 1 | Write data to the memory |
| dram_q | input | 1 | Read data from the memory |

## Verification
Suppose the controller holds a wrong open-row number or a wrong valid flag. Then a later request either skips a needed row activation or triggers an unneeded one. The data check shows this on the next read of that cell, and the strobe-count check shows it within one request. A wrong phase counter moves a strobe edge by whole cycles, so the strobe-to-strobe spacing checks see it at the first affected edge. A read sampled too early returns the memory model's not-yet-valid value, which appears on `rd_data` in the same request. A broken row-age counter shows up as an over-long row strobe during a run of page hits, a few dozen cycles after the row opens.

// File: rtl/pdram_pkg.sv
package pdram_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_CLOSE  = 3'd1,
      ST_RSETUP = 3'd2,
      ST_RHOLD  = 3'd3,
      ST_CSETUP = 3'd4,
      ST_CASLO  = 3'd5,
      ST_CPRE   = 3'd6
   } pdram_state_e;
endpackage

// File: rtl/pdram_phase_timer.sv
module pdram_phase_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   output logic [CW-1:0] cyc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cyc <= '0;
      else if (restart)      cyc <= '0;
      else if (cyc != '1)    cyc <= cyc + 1'b1;
   end
endmodule

// File: rtl/pdram_addr_split.sv
module pdram_addr_split #(
   parameter int ROW_W    = 10,
   parameter int COL_W    = 10,
   parameter bit ROW_HIGH = 1'b1,
   localparam int AW      = ROW_W + COL_W
) (
   input  logic [AW-1:0]    addr,
   output logic [ROW_W-1:0] row,
   output logic [COL_W-1:0] col
);
   generate
      if (ROW_HIGH) begin : g_row_high
         assign row = addr[AW-1:COL_W];
         assign col = addr[COL_W-1:0];
      end else begin : g_row_low
         assign row = addr[ROW_W-1:0];
         assign col = addr[AW-1:ROW_W];
      end
   endgenerate
endmodule

// File: rtl/pdram_row_tracker.sv
module pdram_row_tracker #(
   parameter int ROW_W     = 10,
   parameter int T_RAS_MAX = 200,
   parameter int CLOSE_AT  = 190,
   localparam int AGE_W    = $clog2(T_RAS_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_en,
   input  logic             close_en,
   input  logic [ROW_W-1:0] open_row,
   input  logic [ROW_W-1:0] cmp_row,
   output logic             row_valid,
   output logic             hit,
   output logic             age_over
);
   logic [ROW_W-1:0] row_q;
   logic [AGE_W-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_valid <= 1'b0;
         row_q     <= '0;
      end else if (close_en) begin
         row_valid <= 1'b0;
      end else if (open_en) begin
         row_valid <= 1'b1;
         row_q     <= open_row;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          age_q <= '0;
      else if (!row_valid)                 age_q <= '0;
      else if (age_q != AGE_W'(T_RAS_MAX)) age_q <= age_q + 1'b1;
   end

   assign hit      = row_valid && (row_q == cmp_row);
   assign age_over = (age_q >= AGE_W'(CLOSE_AT));
endmodule

// File: rtl/pdram_ctrl.sv
module pdram_ctrl
   import pdram_pkg::*;
#(
   parameter int ROW_W     = 10,
   parameter int COL_W     = 10,
   parameter bit ROW_HIGH  = 1'b1,
   parameter int T_RAH     = 1,
   parameter int T_RCD     = 3,
   parameter int T_CAS     = 3,
   parameter int T_CP      = 2,
   parameter int T_RP      = 3,
   parameter int T_ACC     = 2,
   parameter int T_RAS_MAX = 200,
   localparam int AW       = ROW_W + COL_W,
   localparam int PINS_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [AW-1:0]     req_addr,
   input  logic              req_wdata,
   output logic              rd_valid,
   output logic              rd_data,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic [PINS_W-1:0] dram_addr,
   output logic              dram_d,
   input  logic              dram_q
);
   localparam int CW       = $clog2(T_RP + T_RAH + T_RCD + T_CAS + T_CP + T_ACC + 2);
   localparam int CLOSE_AT = T_RAS_MAX - T_CAS - T_CP - 2;

   generate
      if (T_RAH < 1 || T_CP < 1 || T_RP < 1 || T_CAS < 1) begin : g_bad_min
         $error("pdram_ctrl: every timing count must be at least one cycle");
      end
      if (T_RCD <= T_RAH) begin : g_bad_rcd
         $error("pdram_ctrl: T_RCD must exceed T_RAH");
      end
      if (T_ACC < 1 || T_ACC > T_CAS) begin : g_bad_acc
         $error("pdram_ctrl: T_ACC must lie in 1..T_CAS");
      end
      if (CLOSE_AT <= T_RCD + T_CAS + T_CP) begin : g_bad_ras
         $error("pdram_ctrl: T_RAS_MAX leaves no room for a page cycle");
      end
   endgenerate

   pdram_state_e      state_q, state_d;
   logic [CW-1:0]     cyc;
   logic              accept, open_en, close_en;
   logic              row_valid, hit, age_over;
   logic              hit_q, pend_q, wr_q, wd_q;
   logic [ROW_W-1:0]  row_in, row_q, row_nxt;
   logic [COL_W-1:0]  col_in, col_q, col_nxt;
   logic              wr_nxt, row_phase, col_phase, rd_take;
   logic [PINS_W-1:0] addr_q;
   logic              cas_n_q, we_n_q, rdv_q, rdd_q;
   logic [CW-1:0]     cset_last;

   pdram_addr_split #(
      .ROW_W(ROW_W), .COL_W(COL_W), .ROW_HIGH(ROW_HIGH)
   ) u_split (
      .addr(req_addr), .row(row_in), .col(col_in)
   );

   pdram_row_tracker #(
      .ROW_W(ROW_W), .T_RAS_MAX(T_RAS_MAX), .CLOSE_AT(CLOSE_AT)
   ) u_rows (
      .clk(clk), .rst_n(rst_n), .open_en(open_en), .close_en(close_en),
      .open_row(row_q), .cmp_row(row_in),
      .row_valid(row_valid), .hit(hit), .age_over(age_over)
   );

   pdram_phase_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(state_d != state_q), .cyc(cyc)
   );

   assign cset_last = hit_q ? '0 : CW'(T_RCD - T_RAH - 1);
   assign req_ready = (state_q == ST_IDLE) && !(row_valid && age_over);

   always_comb begin
      state_d  = state_q;
      accept   = 1'b0;
      open_en  = 1'b0;
      close_en = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (row_valid && age_over) begin
               state_d  = ST_CLOSE;
               close_en = 1'b1;
            end else if (req_valid) begin
               accept = 1'b1;
               if (!row_valid) begin
                  state_d = ST_RSETUP;
               end else if (hit) begin
                  state_d = ST_CSETUP;
               end else begin
                  state_d  = ST_CLOSE;
                  close_en = 1'b1;
               end
            end
         end
         ST_CLOSE:  if (cyc == CW'(T_RP - 1))  state_d = pend_q ? ST_RSETUP : ST_IDLE;
         ST_RSETUP: begin
            state_d = ST_RHOLD;
            open_en = 1'b1;
         end
         ST_RHOLD:  if (cyc == CW'(T_RAH - 1)) state_d = ST_CSETUP;
         ST_CSETUP: if (cyc == cset_last)      state_d = ST_CASLO;
         ST_CASLO:  if (cyc == CW'(T_CAS - 1)) state_d = ST_CPRE;
         ST_CPRE:   if (cyc == CW'(T_CP - 1))  state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   assign row_nxt   = accept ? row_in : row_q;
   assign col_nxt   = accept ? col_in : col_q;
   assign wr_nxt    = accept ? req_write : wr_q;
   assign row_phase = (state_d == ST_RSETUP) || (state_d == ST_RHOLD);
   assign col_phase = (state_d == ST_CSETUP) || (state_d == ST_CASLO) || (state_d == ST_CPRE);
   assign rd_take   = (state_q == ST_CASLO) && (cyc == CW'(T_ACC - 1)) && !wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         hit_q   <= 1'b0;
         pend_q  <= 1'b0;
         wr_q    <= 1'b0;
         wd_q    <= 1'b0;
         row_q   <= '0;
         col_q   <= '0;
         addr_q  <= '0;
         cas_n_q <= 1'b1;
         we_n_q  <= 1'b1;
         rdv_q   <= 1'b0;
         rdd_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            row_q  <= row_in;
            col_q  <= col_in;
            wr_q   <= req_write;
            wd_q   <= req_wdata;
            hit_q  <= hit;
            pend_q <= 1'b1;
         end else if (state_q == ST_CASLO && state_d == ST_CPRE) begin
            pend_q <= 1'b0;
         end
         if (row_phase)      addr_q <= PINS_W'(row_nxt);
         else if (col_phase) addr_q <= PINS_W'(col_nxt);
         cas_n_q <= (state_d != ST_CASLO);
         we_n_q  <= !(wr_nxt && ((state_d == ST_CSETUP) || (state_d == ST_CASLO)));
         rdv_q   <= rd_take;
         if (rd_take) rdd_q <= dram_q;
      end
   end

   assign dram_ras_n = !row_valid;
   assign dram_cas_n = cas_n_q;
   assign dram_we_n  = we_n_q;
   assign dram_addr  = addr_q;
   assign dram_d     = wd_q;
   assign rd_valid   = rdv_q;
   assign rd_data    = rdd_q;
endmodule

// File: rtl/pdram_ctrl_chk.sv
module pdram_ctrl_chk #(
   parameter int PINS_W    = 10,
   parameter int T_RP      = 3,
   parameter int T_CAS     = 3,
   parameter int T_RAS_MAX = 200
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rd_valid,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [PINS_W-1:0] addr,
   input logic              d
);
   logic [15:0] lo_cnt, hi_cnt, cas_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt  <= '0;
         hi_cnt  <= 16'(T_RP);
         cas_cnt <= '0;
      end else begin
         lo_cnt  <= ras_n ? '0 : ((lo_cnt != '1) ? lo_cnt + 1'b1 : lo_cnt);
         hi_cnt  <= !ras_n ? '0 : ((hi_cnt != '1) ? hi_cnt + 1'b1 : hi_cnt);
         cas_cnt <= cas_n ? '0 : ((cas_cnt != '1) ? cas_cnt + 1'b1 : cas_cnt);
      end
   end

   p_row_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> $stable(addr));
   p_col_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> $stable(addr));
   p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (hi_cnt >= 16'(T_RP)));
   p_we_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> ($stable(we_n) && $stable(d)));
   p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   p_ras_low_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> (lo_cnt < 16'(T_RAS_MAX)));
   p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   p_cas_in_row_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);
   p_cas_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_n) |-> (cas_cnt == 16'(T_CAS)));
endmodule

bind pdram_ctrl pdram_ctrl_chk #(
   .PINS_W(PINS_W), .T_RP(T_RP), .T_CAS(T_CAS), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rd_valid(rd_valid), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
   .we_n(dram_we_n), .addr(dram_addr), .d(dram_d)
);

// File: tb/tb_pdram_ctrl.sv
`timescale 1ns/1ps
module tb_pdram_ctrl;
   localparam int T_RAH = 1, T_RCD = 3, T_CAS = 3, T_CP = 2, T_RP = 3, T_ACC = 2;
   localparam int T_RAS_MAX = 40;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
   logic [19:0] req_addr = '0;
   logic req_ready, rd_valid, rd_data, dram_ras_n, dram_cas_n, dram_we_n, dram_d, dram_q;
   logic [9:0] dram_addr;

   int n_chk = 0, n_err = 0;
   bit mon_en = 1'b0;
   bit mdl [0:4095];
   bit shadow [0:4095];
   logic [9:0] exp_row = '0, exp_col = '0, lat_row = '0, lat_col = '0;
   bit exp_wr = 1'b0, exp_wd = 1'b0;
   logic prev_ras = 1'b1, prev_cas = 1'b1;
   int ras_run = 0, rhi_run = 1000, cas_run = 0, chi_run = 0, acc_cnt = 0, ras_falls = 0;
   bit first_cas = 1'b0;

   always #4 clk = ~clk;

   pdram_ctrl #(
      .T_RAH(T_RAH), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
      .T_RP(T_RP), .T_ACC(T_ACC), .T_RAS_MAX(T_RAS_MAX)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
      .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr),
      .dram_d(dram_d), .dram_q(dram_q)
   );

   function automatic int idx(input logic [9:0] r, input logic [9:0] c);
      return int'({r[2:0], c[8:0]});
   endfunction

   // memory model: data valid only T_ACC cycles after the column strobe falls
   assign dram_q = (!dram_cas_n && acc_cnt >= T_ACC) ? mdl[idx(lat_row, lat_col)]
                                                    : ~mdl[idx(lat_row, lat_col)];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mon_en) begin
         if (prev_ras && !dram_ras_n) begin
            ras_falls++;
            chk(rhi_run >= T_RP, "R5 precharge", rhi_run, T_RP);
            chk(dram_addr == exp_row, "R2 row at RAS fall", int'(dram_addr), int'(exp_row));
            lat_row   = dram_addr;
            first_cas = 1'b1;
         end
         if (!prev_ras && dram_ras_n)
            chk(ras_run <= T_RAS_MAX, "R8 RAS low time", ras_run, T_RAS_MAX);
         if (!dram_ras_n && ras_run < T_RAH)
            chk(dram_addr == exp_row, "R3 row hold", int'(dram_addr), int'(exp_row));
         if (prev_cas && !dram_cas_n) begin
            lat_col = dram_addr;
            chk(!dram_ras_n, "R10 CAS inside row", int'(dram_ras_n), 0);
            chk(dram_addr == exp_col, "R2 column at CAS fall", int'(dram_addr), int'(exp_col));
            if (first_cas) chk(ras_run == T_RCD, "R3 RAS to CAS", ras_run, T_RCD);
            else           chk(chi_run >= T_CP, "R10 CAS precharge", chi_run, T_CP);
            first_cas = 1'b0;
            chk(dram_we_n == !exp_wr, "R6 write enable", int'(dram_we_n), int'(!exp_wr));
            if (!dram_we_n) begin
               chk(dram_d == exp_wd, "R6 write data", int'(dram_d), int'(exp_wd));
               mdl[idx(lat_row, dram_addr)] = dram_d;
            end
            acc_cnt = 0;
         end
         if (!prev_cas && dram_cas_n)
            chk(cas_run == T_CAS, "R10 CAS width", cas_run, T_CAS);
         ras_run = dram_ras_n ? 0 : ras_run + 1;
         rhi_run = dram_ras_n ? rhi_run + 1 : 0;
         cas_run = dram_cas_n ? 0 : cas_run + 1;
         chi_run = (dram_cas_n && !dram_ras_n) ? chi_run + 1 : 0;
         acc_cnt = dram_cas_n ? 0 : acc_cnt + 1;
         prev_ras = dram_ras_n;
         prev_cas = dram_cas_n;
      end
   end

   task automatic do_req(input bit wr, input logic [19:0] a, input bit wd);
      int pulses;
      bit got;
      pulses = 0;
      got    = 1'b0;
      @(negedge clk);
      exp_row = a[19:10];
      exp_col = a[9:0];
      exp_wr  = wr;
      exp_wd  = wd;
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R9 ready drops after accept", int'(req_ready), 0);
      while (!req_ready) begin
         if (rd_valid) begin
            pulses++;
            got = rd_data;
         end
         @(negedge clk);
      end
      if (wr) begin
         shadow[idx(a[19:10], a[9:0])] = wd;
         chk(pulses == 0, "R7 no pulse on write", pulses, 0);
      end else begin
         chk(pulses == 1, "R7 one pulse per read", pulses, 1);
         chk(got == shadow[idx(a[19:10], a[9:0])], "R7 read data",
             int'(got), int'(shadow[idx(a[19:10], a[9:0])]));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int f0;
      void'($urandom(32'd4242));
      for (int i = 0; i < 4096; i++) begin
         mdl[i]    = 1'b0;
         shadow[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes high in reset",
          int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
      chk(req_ready && !rd_valid, "R1 ready/valid in reset", int'({req_ready, rd_valid}), 2);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dram_ras_n && req_ready, "R1 no row open after reset",
          int'({dram_ras_n, req_ready}), 3);
      mon_en = 1'b1;

      // R4: page hit keeps the row open
      do_req(1'b1, {10'd5, 10'd1}, 1'b1);
      f0 = ras_falls;
      do_req(1'b1, {10'd5, 10'd2}, 1'b1);
      do_req(1'b0, {10'd5, 10'd1}, 1'b0);
      chk(ras_falls == f0, "R4 hits add no row activation", ras_falls, f0);
      // R5: row miss reopens
      do_req(1'b0, {10'd6, 10'd2}, 1'b0);
      chk(ras_falls == f0 + 1, "R5 miss reopens row", ras_falls, f0 + 1);
      // R8: long run of hits forces closes
      f0 = ras_falls;
      for (int k = 0; k < 20; k++) do_req(k[0], {10'd6, 10'(k)}, k[1]);
      chk(ras_falls >= f0 + 2, "R8 forced close during hits", ras_falls, f0 + 2);
      // corner addresses
      do_req(1'b1, {10'd1023, 10'd1023}, 1'b1);
      do_req(1'b0, {10'd1023, 10'd1023}, 1'b0);
      do_req(1'b1, 20'd0, 1'b1);
      do_req(1'b0, 20'd0, 1'b0);
      // R2/R6/R7: random mix over a few rows
      for (int n = 0; n < 300; n++) begin
         logic [31:0] r;
         r = $urandom;
         do_req(r[0], {8'd0, r[2:1], r[12:3]}, r[13]);
      end
      repeat (60) @(negedge clk);
      chk(dram_ras_n, "R8 idle open row is closed", int'(dram_ras_n), 1);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule